// File: doc/BRIEF.md
# Processor Memory-Map Decoder and Bus Controller

This block sits between a processor's external bus and three kinds of device: a RAM region, a ROM region and one small peripheral with four register locations. It decodes the 16-bit address into a separate select for each device. It also turns the processor's memory clock and direction strobe into read and write strobes for memory, and it controls which side drives the 8-bit data lines.

A transfer lasts one memory-clock period. The period begins with the memory clock low and ends on the clock's falling edge, which is when the transfer takes effect. In a read, the controller never drives the memory data lines. The output enable rises only in the second (high) half, and the selected device's byte is captured at the falling edge. In a write, the controller drives the data lines for the whole transfer and raises the write enable in the second half. The falling edge of the write enable therefore coincides with the end of the transfer.

All logic runs on a fast system clock. The memory clock is sampled as an ordinary input, and every output is registered one system-clock cycle after the inputs that cause it.

Top module: `mmapBusController`

## Requirements
- R1: While reset is held, and right after it is released with the memory clock low, every select, the output enable, the write enable, the drive flag and the read-valid pulse are 0, and the read-data register holds 8'hFF.
- R2: `ramSel` is 1 exactly when address bit 15 is 0 ($0000-$7FFF). It appears one system-clock cycle after the address.
- R3: `romSel` is 1 exactly when address bits 15:12 lie between 4'hB and 4'hE inclusive ($B000-$EFFF). It has one cycle of latency.
- R4: `ioSel` is 1 exactly when address bits 15:2 equal those of $F574 ($F574-$F577). `memAddr` repeats the full address one cycle later, so bits 1:0 pick the register.
- R5: At most one select is ever 1. An address in an unmapped hole ($8000-$AFFF, and $F000-$FFFF except $F574-$F577) raises none.
- R6: `memOe` is 1 only while the memory clock is high in a read transfer to a mapped address, delayed by one cycle. It is 0 during the first half.
- R7: `memWe` is 1 only while the memory clock is high in a write transfer to a mapped address, delayed by one cycle. Its falling edge, one cycle after the memory clock falls, is the moment of the write, and the byte written is the processor's write data.
- R8: `memWrDrive` equals the direction strobe one cycle later. It is 1 for the whole of a write transfer, and it is never 1 together with `memOe`.
- R9: One cycle after the memory clock falls in a read transfer, `cpuRdValid` is 1 for exactly one cycle, and `cpuRdData` holds the byte the selected device presented.
- R10: A read from an unmapped address keeps `memOe` at 0 and returns 8'hFF.
- R11: A write to an unmapped address keeps `memWe` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 16 | Processor address bus |
| cpuWrData | input | 8 | Byte the processor writes |
| cpuWrite | input | 1 | 1 for a write transfer, 0 for a read |
| memClk | input | 1 | Memory clock; a transfer ends on its falling edge |
| memRdData | input | 8 | Byte presented by the enabled device |
| cpuRdData | output | 8 | Byte captured for the processor at the end of a read |
| cpuRdValid | output | 1 | One-cycle pulse when `cpuRdData` is updated by a read |
| memAddr | output | 16 | Registered address to the devices |
| memWrData | output | 8 | Registered write byte to the devices |
| memWrDrive | output | 1 | 1 while the controller drives the memory data lines |
| memOe | output | 1 | Output enable to the selected device |
| memWe | output | 1 | Write enable to the selected device |
| ramSel | output | 1 | RAM chip enable |
| romSel | output | 1 | ROM chip enable |
| ioSel | output | 1 | Peripheral chip enable |

## Verification
Every result lands one system-clock cycle after its cause. Selects, `memAddr` and `memWrDrive` follow the address and direction after one rising edge. `memOe` and `memWe` follow a change of the memory clock after one edge. The read capture and the write-enable fall appear one edge after the memory clock drops. The bench changes inputs just after a falling system-clock edge and samples at the next falling edge, so exactly one rising edge lies between stimulus and check. The full address sweep applies one address per cycle and compares each select against a map that the bench computes by itself.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

  // Selects produced by the address decoder
  typedef struct packed {
    logic ram;
    logic rom;
    logic io;
  } devSel_t;

  // Strobes from the control path to the datapath
  typedef struct packed {
    logic oePhase;   // read transfer, second half
    logic wePhase;   // write transfer, second half
    logic driveBus;  // controller owns the data lines
    logic capture;   // end of a read transfer
  } busStrobe_t;

endpackage

// File: rtl/mmapAddrDecode.sv
module mmapAddrDecode
  import mmap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int REGION_W = 4,
  parameter logic [ADDR_W-1:0] RAM_END = 16'h7FFF,
  parameter logic [REGION_W-1:0] ROM_FIRST = 4'hB,
  parameter logic [REGION_W-1:0] ROM_LAST = 4'hE,
  parameter logic [ADDR_W-1:0] IO_BASE = 16'hF574,
  parameter int IO_ADDR_BITS = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output devSel_t           sel
);
  localparam int IO_TAG_W = ADDR_W - IO_ADDR_BITS;

  logic [REGION_W-1:0] region;
  logic [IO_TAG_W-1:0] ioTag;
  logic ramHit;
  logic romHit;
  logic ioHit;

  assign region = addr[ADDR_W-1 -: REGION_W];
  assign ioTag  = addr[ADDR_W-1 -: IO_TAG_W];
  assign ramHit = (addr <= RAM_END);
  assign ioHit  = (ioTag == IO_BASE[ADDR_W-1 -: IO_TAG_W]);

  generate
    if (ROM_FIRST == ROM_LAST) begin : g_romSingle
      assign romHit = (region == ROM_FIRST);
    end else begin : g_romRange
      assign romHit = (region >= ROM_FIRST) && (region <= ROM_LAST);
    end
  endgenerate

  // Fixed priority keeps the selects exclusive even with overlapping parameters
  always_comb begin
    sel.ram = ramHit;
    sel.rom = romHit && !ramHit;
    sel.io  = ioHit && !ramHit && !romHit;
  end

endmodule

// File: rtl/mmapBusCtrl.sv
module mmapBusCtrl
  import mmap_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       memClk,
  input  logic       cpuWrite,
  output busStrobe_t strb
);
  logic memClkQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) memClkQ <= 1'b0;
    else       memClkQ <= memClk;
  end

  always_comb begin
    strb.oePhase  = memClk && !cpuWrite;
    strb.wePhase  = memClk && cpuWrite;
    strb.driveBus = cpuWrite;
    strb.capture  = memClkQ && !memClk && !cpuWrite;
  end

endmodule

// File: rtl/mmapBusDatapath.sv
module mmapBusDatapath
  import mmap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int REGION_W = 4,
  parameter logic [ADDR_W-1:0] RAM_END = 16'h7FFF,
  parameter logic [REGION_W-1:0] ROM_FIRST = 4'hB,
  parameter logic [REGION_W-1:0] ROM_LAST = 4'hE,
  parameter logic [ADDR_W-1:0] IO_BASE = 16'hF574,
  parameter int IO_ADDR_BITS = 2,
  parameter logic [DATA_W-1:0] IDLE_DATA = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strb,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] cpuRdData,
  output logic              cpuRdValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              memWrDrive,
  output logic              memOe,
  output logic              memWe,
  output devSel_t           selQ
);
  devSel_t selNow;
  logic    anyNow;
  logic    anyQ;

  mmapAddrDecode #(
    .ADDR_W(ADDR_W), .REGION_W(REGION_W), .RAM_END(RAM_END),
    .ROM_FIRST(ROM_FIRST), .ROM_LAST(ROM_LAST),
    .IO_BASE(IO_BASE), .IO_ADDR_BITS(IO_ADDR_BITS)
  ) i_decode (
    .addr(cpuAddr),
    .sel (selNow)
  );

  assign anyNow = selNow.ram || selNow.rom || selNow.io;
  assign anyQ   = selQ.ram || selQ.rom || selQ.io;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ       <= '0;
      memAddr    <= '0;
      memWrData  <= '0;
      memWrDrive <= 1'b0;
      memOe      <= 1'b0;
      memWe      <= 1'b0;
    end else begin
      selQ       <= selNow;
      memAddr    <= cpuAddr;
      memWrData  <= cpuWrData;
      memWrDrive <= strb.driveBus;
      memOe      <= strb.oePhase && anyNow;
      memWe      <= strb.wePhase && anyNow;
    end
  end

  // Read capture at the end of a read transfer; holes yield the idle byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuRdData  <= IDLE_DATA;
      cpuRdValid <= 1'b0;
    end else begin
      cpuRdValid <= strb.capture;
      if (strb.capture) cpuRdData <= anyQ ? memRdData : IDLE_DATA;
    end
  end

  a_r5_one_select: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({selQ.ram, selQ.rom, selQ.io}));

  a_r8_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    !(memWrDrive && memOe));

  a_r6_oe_needs_select: assert property (@(posedge clk) disable iff (!rstN)
    memOe |-> anyQ);

  a_r7_we_while_driving: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memWrDrive && anyQ));

  a_r9_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    cpuRdValid |=> !cpuRdValid);

  a_r2_ram_low_half: assert property (@(posedge clk) disable iff (!rstN)
    selQ.ram |-> !memAddr[ADDR_W-1]);

endmodule

// File: rtl/mmapBusController.sv
module mmapBusController
  import mmap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int REGION_W = 4,
  parameter logic [ADDR_W-1:0] RAM_END = 16'h7FFF,
  parameter logic [REGION_W-1:0] ROM_FIRST = 4'hB,
  parameter logic [REGION_W-1:0] ROM_LAST = 4'hE,
  parameter logic [ADDR_W-1:0] IO_BASE = 16'hF574,
  parameter int IO_ADDR_BITS = 2,
  parameter logic [DATA_W-1:0] IDLE_DATA = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              cpuWrite,
  input  logic              memClk,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] cpuRdData,
  output logic              cpuRdValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              memWrDrive,
  output logic              memOe,
  output logic              memWe,
  output logic              ramSel,
  output logic              romSel,
  output logic              ioSel
);
  busStrobe_t strb;
  devSel_t    selQ;

  mmapBusCtrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .memClk  (memClk),
    .cpuWrite(cpuWrite),
    .strb    (strb)
  );

  mmapBusDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REGION_W(REGION_W), .RAM_END(RAM_END),
    .ROM_FIRST(ROM_FIRST), .ROM_LAST(ROM_LAST), .IO_BASE(IO_BASE),
    .IO_ADDR_BITS(IO_ADDR_BITS), .IDLE_DATA(IDLE_DATA)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cpuAddr   (cpuAddr),
    .cpuWrData (cpuWrData),
    .memRdData (memRdData),
    .cpuRdData (cpuRdData),
    .cpuRdValid(cpuRdValid),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .memWrDrive(memWrDrive),
    .memOe     (memOe),
    .memWe     (memWe),
    .selQ      (selQ)
  );

  assign ramSel = selQ.ram;
  assign romSel = selQ.rom;
  assign ioSel  = selQ.io;

endmodule

// File: tb/test_mmapBusController.sv
`timescale 1ns/1ps
module test_mmapBusController;
  localparam int HALF = 4;
  localparam int WATCHDOG_CYCLES = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuWrData = '0;
  logic        cpuWrite = 1'b0;
  logic        memClk = 1'b0;
  logic [7:0]  memRdData;
  logic [7:0]  cpuRdData;
  logic        cpuRdValid;
  logic [15:0] memAddr;
  logic [7:0]  memWrData;
  logic        memWrDrive, memOe, memWe, ramSel, romSel, ioSel;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mmapBusController i_mmapBusController (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuWrite(cpuWrite), .memClk(memClk), .memRdData(memRdData),
    .cpuRdData(cpuRdData), .cpuRdValid(cpuRdValid), .memAddr(memAddr),
    .memWrData(memWrData), .memWrDrive(memWrDrive), .memOe(memOe),
    .memWe(memWe), .ramSel(ramSel), .romSel(romSel), .ioSel(ioSel)
  );

  // Device models
  logic [7:0] ramModel [256];
  logic [7:0] ioModel [4];
  logic weSeen = 1'b0;

  function automatic logic [7:0] romByte(input logic [15:0] a);
    return a[7:0] ^ a[15:8];
  endfunction

  function automatic logic expRam(input logic [15:0] a); return a < 16'h8000; endfunction
  function automatic logic expRom(input logic [15:0] a); return a >= 16'hB000 && a <= 16'hEFFF; endfunction
  function automatic logic expIo(input logic [15:0] a);  return a >= 16'hF574 && a <= 16'hF577; endfunction

  always_comb begin
    memRdData = 8'h00;
    if (memOe && ramSel) memRdData = ramModel[memAddr[7:0]];
    else if (memOe && romSel) memRdData = romByte(memAddr);
    else if (memOe && ioSel) memRdData = ioModel[memAddr[1:0]];
  end

  always @(negedge clk) begin
    weSeen <= memWe;
    if (weSeen && !memWe) begin
      if (ramSel) ramModel[memAddr[7:0]] <= memWrData;
      else if (ioSel) ioModel[memAddr[1:0]] <= memWrData;
    end
  end

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkReset();
    @(negedge clk);
    check({ramSel, romSel, ioSel, memOe, memWe, memWrDrive, cpuRdValid} == 7'b0, "R1 in reset",
          {9'b0, ramSel, romSel, ioSel, memOe, memWe, memWrDrive, cpuRdValid}, 16'h0);
    check(cpuRdData == 8'hFF, "R1 read data", {8'h0, cpuRdData}, 16'h00FF);
    rstN = 1'b1;
    cpuAddr = 16'h8000;
    @(negedge clk);
    check({ramSel, romSel, ioSel, memOe, memWe, memWrDrive, cpuRdValid} == 7'b0, "R1 after release",
          {9'b0, ramSel, romSel, ioSel, memOe, memWe, memWrDrive, cpuRdValid}, 16'h0);
  endtask

  // One address per cycle, memory clock idle low
  task automatic sweepMap();
    logic [15:0] prev;
    cpuWrite = 1'b0;
    memClk = 1'b0;
    cpuAddr = 16'h0000;
    for (int a = 1; a <= 65536; a++) begin
      @(negedge clk);
      prev = cpuAddr;
      check(ramSel == expRam(prev), "R2 ram select", {15'b0, ramSel}, {15'b0, expRam(prev)});
      check(romSel == expRom(prev), "R3 rom select", {15'b0, romSel}, {15'b0, expRom(prev)});
      check(ioSel == expIo(prev), "R4 io select", {15'b0, ioSel}, {15'b0, expIo(prev)});
      check(memAddr == prev, "R4 address passthrough", memAddr, prev);
      if (!expRam(prev) && !expRom(prev) && !expIo(prev))
        check({ramSel, romSel, ioSel} == 3'b0, "R5 hole", {13'b0, ramSel, romSel, ioSel}, 16'h0);
      if (a < 65536) cpuAddr = a[15:0];
    end
  endtask

  task automatic busCycle(input logic [15:0] a, input logic wr, input logic [7:0] wd,
                          input logic [7:0] expRd);
    logic mapped;
    mapped = expRam(a) || expRom(a) || expIo(a);
    @(negedge clk);
    cpuAddr = a; cpuWrite = wr; cpuWrData = wd; memClk = 1'b0;
    for (int i = 0; i < HALF; i++) begin
      @(negedge clk);
      check(!memOe && !memWe, "R6 first half quiet", {14'b0, memOe, memWe}, 16'h0);
      check(memWrDrive == wr, "R8 drive follows direction", {15'b0, memWrDrive}, {15'b0, wr});
    end
    memClk = 1'b1;
    for (int i = 0; i < HALF; i++) begin
      @(negedge clk);
      check(memOe == (!wr && mapped), wr ? "R6 oe off in write" : (mapped ? "R6 oe in read" : "R10 oe off in hole"),
            {15'b0, memOe}, {15'b0, !wr && mapped});
      check(memWe == (wr && mapped), mapped ? "R7 we in write" : "R11 we off in hole",
            {15'b0, memWe}, {15'b0, wr && mapped});
      check(!(memOe && memWrDrive), "R8 no contention", {14'b0, memOe, memWrDrive}, 16'h0);
    end
    memClk = 1'b0;
    @(negedge clk);
    check(cpuRdValid == !wr, "R9 valid pulse", {15'b0, cpuRdValid}, {15'b0, !wr});
    check(!memOe && !memWe, "R7 strobes drop at end", {14'b0, memOe, memWe}, 16'h0);
    if (!wr)
      check(cpuRdData == expRd, mapped ? "R9 read data" : "R10 hole default",
            {8'h0, cpuRdData}, {8'h0, expRd});
    @(negedge clk);
    check(cpuRdValid == 1'b0, "R9 single pulse", {15'b0, cpuRdValid}, 16'h0);
  endtask

  task automatic ramTraffic();
    busCycle(16'h1234, 1'b1, 8'hA5, 8'h00);
    busCycle(16'h1235, 1'b1, 8'h5A, 8'h00);
    busCycle(16'h1234, 1'b0, 8'h00, 8'hA5);   // R7 write landed, R9 readback
    busCycle(16'h7F35, 1'b0, 8'h00, 8'h5A);   // aliasing model, top of RAM
  endtask

  task automatic romTraffic();
    busCycle(16'hB000, 1'b0, 8'h00, romByte(16'hB000));
    busCycle(16'hEFFF, 1'b0, 8'h00, romByte(16'hEFFF));
    busCycle(16'hC3C3, 1'b0, 8'h00, romByte(16'hC3C3));
  endtask

  task automatic ioTraffic();
    busCycle(16'hF576, 1'b1, 8'h3C, 8'h00);
    busCycle(16'hF576, 1'b0, 8'h00, 8'h3C);   // R4 register 2
    busCycle(16'hF577, 1'b0, 8'h00, 8'h00);   // R4 register 3 untouched
  endtask

  task automatic holeTraffic();
    busCycle(16'h8000, 1'b0, 8'h00, 8'hFF);   // R10
    busCycle(16'hF578, 1'b0, 8'h00, 8'hFF);   // R10 just past the peripheral
    busCycle(16'hF000, 1'b1, 8'h77, 8'h00);   // R11
    busCycle(16'hF573, 1'b1, 8'h77, 8'h00);   // R11 just before the peripheral
    busCycle(16'hF574, 1'b0, 8'h00, 8'h00);   // register 0 still clear
    busCycle(16'h1234, 1'b0, 8'h00, 8'hA5);   // RAM unchanged
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ramModel[i] = 8'h00;
    for (int i = 0; i < 4; i++) ioModel[i] = 8'h00;
    repeat (3) @(negedge clk);
    checkReset();
    sweepMap();
    ramTraffic();
    romTraffic();
    ioTraffic();
    holeTraffic();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule